// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block sits on the receive side of an I2C target. It oversamples the SCL and SDA pins in the system clock domain and detects START, repeated START and STOP. It shifts in the byte that follows each START and compares it in hardware against a slave address that the host programs. On a match it sets an addressed flag and pulls SDA low for the acknowledge clock. Every byte it accepts is handed to the host register interface, together with a one-cycle done strobe.

Two addressing modes are supported. In 7-bit mode the direction bit of the header plays no part in the compare. In 10-bit mode the whole first byte is compared, and its last bit must equal a host-owned direction-compare bit. The second byte of a 10-bit address is not compared in hardware. It is acknowledged and passed to the host, which checks it. After that check the host sets the direction-compare bit, so that a read header sent after a repeated START is accepted by the hardware compare.

Top module: `i2cam_top`

## Requirements
- R1: Out of reset, sdaDriveLow, addressed, byteDone, startSeen and stopSeen are 0 and rxByte is 0.
- R2: SDA falling while SCL is high gives a one-cycle startSeen pulse (also for a repeated START). SDA rising while SCL is high gives a one-cycle stopSeen pulse. The two never pulse together.
- R3: With modeTenBit = 0, header bits 7..1 (received MSB first) are compared with slaveAddr[6:0] and header bit 0 is ignored. On a match the header is acknowledged and addressed becomes 1.
- R4: A header that does not match gets no acknowledge. Until the next START, later bytes produce neither byteDone nor an acknowledge.
- R5: With modeTenBit = 1, a header matches only when bits 7..1 equal slaveAddr and bit 0 equals dirCompare.
- R6: After a matching header with bit 0 = 0, every following byte is exposed on rxByte with byteDone and is acknowledged, whatever its value. This includes the second byte of a 10-bit address.
- R7: In 10-bit mode with dirCompare = 1, a header with bit 0 = 1 after a repeated START is acknowledged and addressed stays 1.
- R8: byteDone is high for exactly one cycle per accepted byte, after its eighth SCL rise. rxByte then holds that byte MSB first and does not change between pulses.
- R9: A STOP clears addressed and releases SDA.
- R10: A START leaves addressed unchanged until its header completes. A header that does not match then clears addressed.
- R11: sdaDriveLow is asserted only while addressed is 1. It rises after the SCL fall that follows the eighth bit and drops after the SCL fall that ends the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL pin level, asynchronous |
| sdaIn | input | 1 | SDA pin level, asynchronous |
| modeTenBit | input | 1 | 0 = 7-bit addressing, 1 = 10-bit addressing |
| slaveAddr | input | 7 | Programmed slave address compared with header bits 7..1 |
| dirCompare | input | 1 | Direction-compare bit, used in 10-bit mode only |
| sdaDriveLow | output | 1 | 1 = pull SDA low (acknowledge) |
| addressed | output | 1 | Addressed-as-slave flag |
| rxByte | output | 8 | Last accepted byte |
| byteDone | output | 1 | One-cycle strobe when rxByte is updated |
| startSeen | output | 1 | One-cycle strobe on START or repeated START |
| stopSeen | output | 1 | One-cycle strobe on STOP |

## Verification
A pin change reaches the synchronised level two clocks after it is driven. Edge and condition flags are then valid combinationally, so startSeen, stopSeen and the clearing of addressed on STOP appear on the third edge. After the eighth SCL rise, the shift register updates on the third edge and byteDone, rxByte and addressed update on the fourth. sdaDriveLow changes three edges after the SCL fall it follows. The bench holds each SCL half-period for eight clocks and samples at the falling clock edge at the end of a half-period, so every result is settled when it is read. Strobes are counted by a falling-edge monitor, so each pulse is counted exactly once.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;

  // Bus events produced by the datapath for the controller.
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startCond;
    logic stopCond;
    logic byteFull;
    logic addrHit;
    logic rwBit;
  } busEvt_t;

  // Strobes sent by the controller to the datapath.
  typedef struct packed {
    logic shiftEn;
    logic clearCnt;
    logic latchByte;
  } ctlStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_PREACK,
    ST_ACKLOW,
    ST_ACKHOLD
  } ctlState_t;

endpackage

// File: rtl/i2cam_sync.sv
module i2cam_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '1;
        else       pipe <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '1;
        else       pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/i2cam_datapath.sv
module i2cam_datapath
  import i2cam_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              modeTenBit,
  input  logic [ADDR_W-1:0] slaveAddr,
  input  logic              dirCompare,
  input  ctlStrobe_t        strobe,
  output busEvt_t           evt,
  output logic [ADDR_W:0]   rxByte
);

  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

  logic sclS, sdaS, sclD, sdaD;
  logic [BYTE_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic headMatch, dirOk;

  i2cam_sync #(.STAGES(SYNC_STAGES)) i_syncScl (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclS)
  );
  i2cam_sync #(.STAGES(SYNC_STAGES)) i_syncSda (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaS)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      rxByte   <= '0;
    end else begin
      if (strobe.clearCnt) begin
        bitCnt <= '0;
      end else if (strobe.shiftEn && evt.sclRise) begin
        shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
        bitCnt   <= bitCnt + 1'b1;
      end
      if (strobe.latchByte) rxByte <= shiftReg;
    end
  end

  assign headMatch = (shiftReg[BYTE_W-1:1] == slaveAddr);
  assign dirOk     = !modeTenBit || (shiftReg[0] == dirCompare);

  always_comb begin
    evt.sclRise   = sclS && !sclD;
    evt.sclFall   = !sclS && sclD;
    evt.startCond = sclS && sclD && sdaD && !sdaS;
    evt.stopCond  = sclS && sclD && !sdaD && sdaS;
    evt.byteFull  = (bitCnt == FULL_CNT);
    evt.addrHit   = headMatch && dirOk;
    evt.rwBit     = shiftReg[0];
  end

endmodule

// File: rtl/i2cam_control.sv
module i2cam_control
  import i2cam_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  busEvt_t    evt,
  output ctlStrobe_t strobe,
  output logic       sdaDriveLow,
  output logic       addressed,
  output logic       byteDone,
  output logic       startSeen,
  output logic       stopSeen
);

  ctlState_t state;
  logic isHeader;   // next completed byte is a header
  logic ackData;    // data bytes of this transfer are acknowledged
  logic ackThis;    // acknowledge the byte just completed

  always_comb begin
    strobe.shiftEn   = (state == ST_SHIFT) && !evt.byteFull;
    strobe.latchByte = (state == ST_SHIFT) && evt.byteFull;
    strobe.clearCnt  = evt.startCond || ((state == ST_SHIFT) && evt.byteFull);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      isHeader    <= 1'b0;
      ackData     <= 1'b0;
      ackThis     <= 1'b0;
      sdaDriveLow <= 1'b0;
      addressed   <= 1'b0;
      byteDone    <= 1'b0;
      startSeen   <= 1'b0;
      stopSeen    <= 1'b0;
    end else begin
      byteDone  <= 1'b0;
      startSeen <= evt.startCond;
      stopSeen  <= evt.stopCond;
      if (evt.stopCond) begin
        state       <= ST_IDLE;
        isHeader    <= 1'b0;
        addressed   <= 1'b0;
        sdaDriveLow <= 1'b0;
      end else if (evt.startCond) begin
        state       <= ST_SHIFT;
        isHeader    <= 1'b1;
        sdaDriveLow <= 1'b0;
      end else begin
        unique case (state)
          ST_SHIFT: begin
            if (evt.byteFull) begin
              byteDone <= 1'b1;
              state    <= ST_PREACK;
              if (isHeader) begin
                isHeader <= 1'b0;
                if (evt.addrHit) begin
                  addressed <= 1'b1;
                  ackThis   <= 1'b1;
                  ackData   <= !evt.rwBit;
                end else begin
                  addressed <= 1'b0;
                  ackThis   <= 1'b0;
                  ackData   <= 1'b0;
                end
              end else begin
                ackThis <= ackData;
              end
            end
          end
          ST_PREACK: begin
            if (evt.sclFall) begin
              if (ackThis) begin
                sdaDriveLow <= 1'b1;
                state       <= ST_ACKLOW;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ACKLOW: begin
            if (evt.sclRise) state <= ST_ACKHOLD;
          end
          ST_ACKHOLD: begin
            if (evt.sclFall) begin
              sdaDriveLow <= 1'b0;
              state       <= ackData ? ST_SHIFT : ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2cam_top.sv
module i2cam_top
  import i2cam_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              modeTenBit,
  input  logic [ADDR_W-1:0] slaveAddr,
  input  logic              dirCompare,
  output logic              sdaDriveLow,
  output logic              addressed,
  output logic [ADDR_W:0]   rxByte,
  output logic              byteDone,
  output logic              startSeen,
  output logic              stopSeen
);

  busEvt_t    evt;
  ctlStrobe_t strobe;

  i2cam_datapath #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .modeTenBit(modeTenBit), .slaveAddr(slaveAddr), .dirCompare(dirCompare),
    .strobe(strobe), .evt(evt), .rxByte(rxByte)
  );

  i2cam_control i_control (
    .clk(clk), .rstN(rstN), .evt(evt), .strobe(strobe),
    .sdaDriveLow(sdaDriveLow), .addressed(addressed), .byteDone(byteDone),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

endmodule

// File: rtl/i2cam_checker.sv
module i2cam_checker #(
  parameter int ADDR_W = 7
) (
  input logic            clk,
  input logic            rstN,
  input logic            sdaDriveLow,
  input logic            addressed,
  input logic [ADDR_W:0] rxByte,
  input logic            byteDone,
  input logic            startSeen,
  input logic            stopSeen
);

  a_r2_start_stop_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(startSeen && stopSeen));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |=> !byteDone);

  a_r8_rx_held: assert property (@(posedge clk) disable iff (!rstN)
    (rxByte != $past(rxByte)) |-> byteDone);

  a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |-> (!addressed && !sdaDriveLow));

  a_r11_drive_needs_match: assert property (@(posedge clk) disable iff (!rstN)
    sdaDriveLow |-> addressed);

endmodule

bind i2cam_top i2cam_checker #(.ADDR_W(ADDR_W)) i_checker (
  .clk(clk), .rstN(rstN), .sdaDriveLow(sdaDriveLow), .addressed(addressed),
  .rxByte(rxByte), .byteDone(byteDone), .startSeen(startSeen), .stopSeen(stopSeen)
);

// File: tb/test_i2cam_top.sv
module test_i2cam_top;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic modeTenBit = 1'b0;
  logic [6:0] slaveAddr = 7'h00;
  logic dirCompare = 1'b0;
  logic sdaLine;
  logic sdaDriveLow, addressed, byteDone, startSeen, stopSeen;
  logic [7:0] rxByte;

  int checks = 0;
  int fails = 0;
  int doneCnt = 0, startCnt = 0, stopCnt = 0;
  logic [7:0] lastRx = 8'h00;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  assign sdaLine = mSda && !sdaDriveLow;

  i2cam_top i_i2cam_top (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine),
    .modeTenBit(modeTenBit), .slaveAddr(slaveAddr), .dirCompare(dirCompare),
    .sdaDriveLow(sdaDriveLow), .addressed(addressed), .rxByte(rxByte),
    .byteDone(byteDone), .startSeen(startSeen), .stopSeen(stopSeen)
  );

  always @(negedge clk) begin
    if (byteDone) begin
      doneCnt <= doneCnt + 1;
      lastRx  <= rxByte;
    end
    if (startSeen) startCnt <= startCnt + 1;
    if (stopSeen)  stopCnt  <= stopCnt + 1;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitHalf();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic busStart();
    if (!mScl) begin
      mSda = 1'b1; waitHalf();
      mScl = 1'b1; waitHalf();
    end
    mSda = 1'b0; waitHalf();
    mScl = 1'b0; waitHalf();
  endtask

  task automatic busStop();
    mSda = 1'b0; waitHalf();
    mScl = 1'b1; waitHalf();
    mSda = 1'b1; waitHalf();
  endtask

  // Sends one byte MSB first and returns whether SDA was held low
  // through the ninth clock.
  task automatic sendByte(input logic [7:0] b, output logic ackd);
    logic lowBefore;
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitHalf();
      mScl = 1'b1; waitHalf();
      mScl = 1'b0; waitHalf();
    end
    mSda = 1'b1; waitHalf();
    lowBefore = !sdaLine;
    mScl = 1'b1; waitHalf();
    ackd = lowBefore && !sdaLine;
    mScl = 1'b0; waitHalf();
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(!sdaDriveLow && !addressed && !byteDone && !startSeen && !stopSeen,
          "R1 outputs in reset", {sdaDriveLow, addressed, byteDone}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(rxByte == 8'h00 && !addressed && !sdaDriveLow,
          "R1 outputs after reset", rxByte, 0);
  endtask

  task automatic t_seven_match();
    logic ackd;
    int s0, d0;
    modeTenBit = 1'b0; slaveAddr = 7'h5A; dirCompare = 1'b0;
    s0 = startCnt;
    busStart();
    check(startCnt == s0 + 1, "R2 one start pulse", startCnt - s0, 1);
    d0 = doneCnt;
    sendByte(8'hB5, ackd);     // read header: bit 0 ignored in 7-bit mode
    check(ackd && addressed, "R3 read header acked", {ackd, addressed}, 3);
    check(doneCnt == d0 + 1 && lastRx == 8'hB5, "R8 header byte exposed", lastRx, 8'hB5);
    check(!sdaDriveLow, "R11 released after ninth clock", sdaDriveLow, 0);
    s0 = stopCnt;
    busStop();
    check(stopCnt == s0 + 1, "R2 one stop pulse", stopCnt - s0, 1);
    check(!addressed && !sdaDriveLow, "R9 stop clears flag", addressed, 0);
    busStart();
    sendByte(8'hB4, ackd);
    d0 = doneCnt;
    sendByte(8'h3C, ackd);
    check(ackd && doneCnt == d0 + 1, "R6 data byte acked", ackd, 1);
    check(rxByte == 8'h3C && lastRx == 8'h3C, "R8 data byte MSB first", rxByte, 8'h3C);
    busStop();
  endtask

  task automatic t_seven_mismatch();
    logic ackd;
    int d0;
    modeTenBit = 1'b0; slaveAddr = 7'h5A;
    busStart();
    sendByte(8'hB6, ackd);     // 0x5B header
    check(!ackd && !addressed, "R4 mismatched header not acked", ackd, 0);
    d0 = doneCnt;
    sendByte(8'hB4, ackd);     // would match, but arrives without START
    check(!ackd && doneCnt == d0, "R4 later bytes ignored", doneCnt - d0, 0);
    check(rxByte == 8'hB6, "R8 rxByte held", rxByte, 8'hB6);
    busStop();
  endtask

  task automatic t_ten_bit();
    logic ackd;
    int d0;
    modeTenBit = 1'b1; slaveAddr = 7'h7A; dirCompare = 1'b0;
    busStart();
    sendByte(8'hF5, ackd);     // bit 0 = 1 differs from dirCompare
    check(!ackd && !addressed, "R5 direction bit compared", ackd, 0);
    busStart();
    sendByte(8'hF4, ackd);
    check(ackd && addressed, "R5 full header match", ackd, 1);
    d0 = doneCnt;
    sendByte(8'h9D, ackd);     // second address byte, checked by host
    check(ackd && doneCnt == d0 + 1 && rxByte == 8'h9D,
          "R6 second byte passed to host", rxByte, 8'h9D);
    dirCompare = 1'b1;
    busStart();
    check(addressed, "R10 flag kept during header", addressed, 1);
    sendByte(8'hF5, ackd);
    check(ackd && addressed, "R7 read header after restart", ackd, 1);
    busStop();
    check(!addressed, "R9 stop clears flag in 10-bit", addressed, 0);
  endtask

  task automatic t_restart_mismatch();
    logic ackd;
    modeTenBit = 1'b0; slaveAddr = 7'h21; dirCompare = 1'b0;
    busStart();
    sendByte(8'h42, ackd);
    check(ackd && addressed, "R3 write header acked", ackd, 1);
    busStart();
    check(addressed, "R10 flag unchanged by start", addressed, 1);
    sendByte(8'h22, ackd);
    check(!ackd && !addressed && !sdaDriveLow, "R10 mismatch clears flag", addressed, 0);
    busStop();
  endtask

  initial begin
    t_reset();
    t_seven_match();
    t_seven_mismatch();
    t_ten_bit();
    t_restart_mismatch();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule